// File: doc/BRIEF.md
# Colour Subcarrier Phase Generator

This block produces the running phase of the colour subcarrier that composite and S-video encoders modulate onto chroma. The phase comes from three chained accumulators. The coarse stage holds the phase word and adds a 12-bit step once for every active pixel. Two modulo stages sit below it, each with a 15-bit step and a 15-bit rollover size. When a modulo stage wraps, its carry adds one LSB to the sum of the stage above. This chain lets software hit subcarrier frequencies that are not a whole multiple of the pixel clock divided by a power of two. Each stage can be switched on or off on its own.

A field counter advances on every field-start strobe. It clears all three accumulators every 2nd, 4th or 8th field, or never, so the subcarrier repeats its phase over a chosen number of fields. The phase output is the top eight bits of the coarse accumulator and feeds a sine table placed downstream. An 8-bit burst amplitude is kept in the same register set and is passed out to the amplitude stage that follows.

Top module: `subcarrier_phase_gen`

## Requirements
- R1: After reset, phase_o and burst_lvl_o are 0, all accumulators and the field count are 0, all three stages are disabled and the clear mode is 0.
- R2: With the coarse stage enabled, each cycle with pix_en_i high adds the 12-bit coarse step, plus the carry in from the middle stage, to the coarse accumulator modulo 4096. phase_o shows accumulator bits 11:4 one cycle after the pixel edge.
- R3: In a cycle with pix_en_i low and no clear, no accumulator changes and phase_o holds.
- R4: The middle stage forms acc + step + carry-in from the fine stage. If this sum is greater than or equal to its size, the stage stores sum - size and sends a carry that adds one LSB to the coarse stage in the same pixel. Otherwise it stores the sum and sends no carry.
- R5: The fine stage forms acc + step with the same rollover rule. Its carry adds one LSB to the middle stage's sum in the same pixel.
- R6: A disabled stage keeps its value and produces no carry, even when the stage below it sends a carry.
- R7: The field count goes up by one on every field_start_i strobe. When the clear mode is 0, 1 or 2, a strobe whose new count is a multiple of 2, 4 or 8 clears all accumulators to 0 on that edge.
- R8: Clear mode 3 never clears the accumulators.
- R9: burst_lvl_o shows the stored burst amplitude and follows a write in the next cycle.
- R10: When field_start_i and pix_en_i are high together and the strobe causes a clear, the clear wins and all accumulators are 0 after the edge.
- R11: Register map (write with cfg_we_i). Address 0 holds coarse step [11:0], burst amplitude [19:12], clear mode [21:20], fine enable [24], middle enable [23] and coarse enable [22]. Address 1 holds the middle stage step [14:0] and size [30:16]. Address 2 holds the fine stage step [14:0] and size [30:16]. Writes to address 3 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_en_i | input | 1 | One active pixel in this cycle |
| field_start_i | input | 1 | Field boundary strobe |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 2 | Register address |
| cfg_wdata_i | input | 32 | Register write data |
| phase_o | output | 8 | Subcarrier phase word for the sine table |
| burst_lvl_o | output | 8 | Burst amplitude for the amplitude stage |

## Verification
Every accumulator update, whether a pixel step, a field clear or both in one cycle, shows on phase_o after exactly one clock edge. A register write reaches burst_lvl_o after one edge and first steers the accumulators at the next pixel edge. The bench drives each stimulus at a falling edge and updates its own model of the three stages after the rising edge. It then queues the expected phase and burst values, and the monitor compares them at the next falling edge, half a period after the edge that produced them. Idle cycles are queued in the same way, so holding behaviour is checked on the same schedule.

// File: rtl/scp_pkg.sv
package scp_pkg;

    localparam int SCP_INC1_W = 12;
    localparam int SCP_MOD_W  = 15;
    localparam int SCP_LVL_W  = 8;
    localparam int SCP_FCNT_W = 3;
    localparam int SCP_DATA_W = 32;
    localparam int SCP_ADDR_W = 2;

    typedef enum logic [1:0] {
        CLR_EVERY_2 = 2'd0,
        CLR_EVERY_4 = 2'd1,
        CLR_EVERY_8 = 2'd2,
        CLR_NEVER   = 2'd3
    } scp_clr_mode_e;

    localparam logic [SCP_ADDR_W-1:0] ADDR_CTRL = 2'd0;
    localparam logic [SCP_ADDR_W-1:0] ADDR_MID  = 2'd1;
    localparam logic [SCP_ADDR_W-1:0] ADDR_FINE = 2'd2;

endpackage

// File: rtl/scp_cfg_regs.sv
module scp_cfg_regs
    import scp_pkg::*;
#(
    parameter int INC1_W = SCP_INC1_W,
    parameter int MOD_W  = SCP_MOD_W,
    parameter int LVL_W  = SCP_LVL_W,
    parameter int DATA_W = SCP_DATA_W,
    parameter int ADDR_W = SCP_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [INC1_W-1:0] inc1_o,
    output logic [LVL_W-1:0]  lvl_o,
    output scp_clr_mode_e     mode_o,
    output logic [2:0]        en_o,       // [0]=coarse [1]=middle [2]=fine
    output logic [MOD_W-1:0]  inc_mid_o,
    output logic [MOD_W-1:0]  size_mid_o,
    output logic [MOD_W-1:0]  inc_fine_o,
    output logic [MOD_W-1:0]  size_fine_o
);

    localparam int LVL_LSB  = INC1_W;
    localparam int MODE_LSB = LVL_LSB + LVL_W;
    localparam int EN_LSB   = MODE_LSB + 2;
    localparam int SIZE_LSB = DATA_W / 2;

    typedef struct packed {
        logic [2:0]        en;
        scp_clr_mode_e     mode;
        logic [LVL_W-1:0]  lvl;
        logic [INC1_W-1:0] inc1;
        logic [MOD_W-1:0]  inc_mid;
        logic [MOD_W-1:0]  size_mid;
        logic [MOD_W-1:0]  inc_fine;
        logic [MOD_W-1:0]  size_fine;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en_i) begin
            case (wr_addr_i)
                ADDR_CTRL: begin
                    cfg_d.inc1 = wr_data_i[INC1_W-1:0];
                    cfg_d.lvl  = wr_data_i[LVL_LSB +: LVL_W];
                    cfg_d.mode = scp_clr_mode_e'(wr_data_i[MODE_LSB +: 2]);
                    cfg_d.en   = wr_data_i[EN_LSB +: 3];
                end
                ADDR_MID: begin
                    cfg_d.inc_mid  = wr_data_i[MOD_W-1:0];
                    cfg_d.size_mid = wr_data_i[SIZE_LSB +: MOD_W];
                end
                ADDR_FINE: begin
                    cfg_d.inc_fine  = wr_data_i[MOD_W-1:0];
                    cfg_d.size_fine = wr_data_i[SIZE_LSB +: MOD_W];
                end
                default: cfg_d = cfg_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    logic unused_bits;
    assign unused_bits = ^{wr_data_i[DATA_W-1:EN_LSB+3], wr_data_i[SIZE_LSB-1:MOD_W],
                           wr_data_i[DATA_W-1:SIZE_LSB+MOD_W]};

    assign inc1_o      = cfg_q.inc1;
    assign lvl_o       = cfg_q.lvl;
    assign mode_o      = cfg_q.mode;
    assign en_o        = cfg_q.en;
    assign inc_mid_o   = cfg_q.inc_mid;
    assign size_mid_o  = cfg_q.size_mid;
    assign inc_fine_o  = cfg_q.inc_fine;
    assign size_fine_o = cfg_q.size_fine;

    // R11
    addr3_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_addr_i == 2'd3) |=> (cfg_q == $past(cfg_q)));

endmodule

// File: rtl/scp_field_ctr.sv
module scp_field_ctr
    import scp_pkg::*;
#(
    parameter int FCNT_W = SCP_FCNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          field_start_i,
    input  scp_clr_mode_e mode_i,
    output logic          clr_o
);

    typedef struct packed {
        logic [FCNT_W-1:0] cnt;
    } fstate_t;

    fstate_t st_d, st_q;
    logic [FCNT_W-1:0] cnt_nxt;
    logic              boundary;

    always_comb begin
        st_d     = st_q;
        cnt_nxt  = st_q.cnt + 1'b1;
        boundary = 1'b0;
        case (mode_i)
            CLR_EVERY_2: boundary = (cnt_nxt[0]   == 1'b0);
            CLR_EVERY_4: boundary = (cnt_nxt[1:0] == 2'b00);
            CLR_EVERY_8: boundary = (cnt_nxt[2:0] == 3'b000);
            default:     boundary = 1'b0;
        endcase
        clr_o = field_start_i && boundary;
        if (field_start_i) st_d.cnt = cnt_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R7
    field_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        field_start_i |=> (st_q.cnt == FCNT_W'($past(st_q.cnt) + 1'b1)));

    // R7
    field_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !field_start_i |=> $stable(st_q.cnt));

    // R8
    never_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == CLR_NEVER) |-> !clr_o);

endmodule

// File: rtl/scp_mod_stage.sv
module scp_mod_stage #(
    parameter int W = 15
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step_i,
    input  logic         en_i,
    input  logic         clr_i,
    input  logic [W-1:0] inc_i,
    input  logic [W-1:0] size_i,
    input  logic         cin_i,
    output logic [W-1:0] acc_o,
    output logic         carry_o
);

    typedef struct packed {
        logic [W-1:0] acc;
    } mstate_t;

    mstate_t st_d, st_q;
    logic [W:0] sum;
    logic       wrap;

    always_comb begin
        st_d    = st_q;
        sum     = {1'b0, st_q.acc} + {1'b0, inc_i} + {{W{1'b0}}, cin_i};
        wrap    = (sum >= {1'b0, size_i});
        carry_o = 1'b0;
        if (clr_i) begin
            st_d.acc = '0;
        end else if (step_i && en_i) begin
            carry_o  = wrap;
            st_d.acc = wrap ? W'(sum - {1'b0, size_i}) : sum[W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign acc_o = st_q.acc;

    // R6
    stage_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !clr_i) |=> $stable(acc_o));

    // R6
    no_carry_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i || !step_i) |-> !carry_o);

    // R10
    stage_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (acc_o == '0));

endmodule

// File: rtl/subcarrier_phase_gen.sv
module subcarrier_phase_gen
    import scp_pkg::*;
#(
    parameter int INC1_W  = SCP_INC1_W,
    parameter int MOD_W   = SCP_MOD_W,
    parameter int LVL_W   = SCP_LVL_W,
    parameter int PHASE_W = 8,
    parameter int FCNT_W  = SCP_FCNT_W,
    parameter int DATA_W  = SCP_DATA_W,
    parameter int ADDR_W  = SCP_ADDR_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pix_en_i,
    input  logic               field_start_i,
    input  logic               cfg_we_i,
    input  logic [ADDR_W-1:0]  cfg_addr_i,
    input  logic [DATA_W-1:0]  cfg_wdata_i,
    output logic [PHASE_W-1:0] phase_o,
    output logic [LVL_W-1:0]   burst_lvl_o
);

    localparam int NMOD = 2;   // index 0 = fine stage, 1 = middle stage

    logic [INC1_W-1:0] inc1;
    scp_clr_mode_e     mode;
    logic [2:0]        en;
    logic [MOD_W-1:0]  inc_mid, size_mid, inc_fine, size_fine;
    logic              clr;

    logic [MOD_W-1:0]  m_inc  [NMOD];
    logic [MOD_W-1:0]  m_size [NMOD];
    logic              m_en   [NMOD];
    logic [MOD_W-1:0]  m_acc  [NMOD];
    logic [NMOD:0]     chain;

    scp_cfg_regs #(
        .INC1_W(INC1_W), .MOD_W(MOD_W), .LVL_W(LVL_W),
        .DATA_W(DATA_W), .ADDR_W(ADDR_W)
    ) i_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en_i     (cfg_we_i),
        .wr_addr_i   (cfg_addr_i),
        .wr_data_i   (cfg_wdata_i),
        .inc1_o      (inc1),
        .lvl_o       (burst_lvl_o),
        .mode_o      (mode),
        .en_o        (en),
        .inc_mid_o   (inc_mid),
        .size_mid_o  (size_mid),
        .inc_fine_o  (inc_fine),
        .size_fine_o (size_fine)
    );

    scp_field_ctr #(.FCNT_W(FCNT_W)) i_field (
        .clk           (clk),
        .rst_n         (rst_n),
        .field_start_i (field_start_i),
        .mode_i        (mode),
        .clr_o         (clr)
    );

    assign m_inc[0]  = inc_fine;
    assign m_size[0] = size_fine;
    assign m_en[0]   = en[2];
    assign m_inc[1]  = inc_mid;
    assign m_size[1] = size_mid;
    assign m_en[1]   = en[1];
    assign chain[0]  = 1'b0;

    genvar g;
    generate
        for (g = 0; g < NMOD; g++) begin : g_mod
            scp_mod_stage #(.W(MOD_W)) i_stage (
                .clk     (clk),
                .rst_n   (rst_n),
                .step_i  (pix_en_i),
                .en_i    (m_en[g]),
                .clr_i   (clr),
                .inc_i   (m_inc[g]),
                .size_i  (m_size[g]),
                .cin_i   (chain[g]),
                .acc_o   (m_acc[g]),
                .carry_o (chain[g+1])
            );
        end
    endgenerate

    typedef struct packed {
        logic [INC1_W-1:0] acc;
    } cstate_t;

    cstate_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.acc = '0;
        end else if (pix_en_i && en[0]) begin
            st_d.acc = st_q.acc + inc1 + {{(INC1_W-1){1'b0}}, chain[NMOD]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign phase_o = st_q.acc[INC1_W-1 -: PHASE_W];

    logic unused_acc;
    assign unused_acc = ^{m_acc[0], m_acc[1]};

    // R3
    phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pix_en_i && !clr) |=> $stable(phase_o));

    // R10
    phase_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (phase_o == '0));

    // R6
    coarse_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en[0] && !clr) |=> $stable(phase_o));

endmodule

// File: tb/test_subcarrier_phase_gen.sv
module test_subcarrier_phase_gen;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pix_en_i = 1'b0;
    logic        field_start_i = 1'b0;
    logic        cfg_we_i = 1'b0;
    logic [1:0]  cfg_addr_i = '0;
    logic [31:0] cfg_wdata_i = '0;
    logic [7:0]  phase_o;
    logic [7:0]  burst_lvl_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    subcarrier_phase_gen i_subcarrier_phase_gen (
        .clk           (clk),
        .rst_n         (rst_n),
        .pix_en_i      (pix_en_i),
        .field_start_i (field_start_i),
        .cfg_we_i      (cfg_we_i),
        .cfg_addr_i    (cfg_addr_i),
        .cfg_wdata_i   (cfg_wdata_i),
        .phase_o       (phase_o),
        .burst_lvl_o   (burst_lvl_o)
    );

    typedef struct {
        logic [7:0] ph;
        logic [7:0] lvl;
        string      tag;
    } item_t;

    item_t exp_q[$];
    int total = 0;
    int bad = 0;
    bit done = 0;

    // model state
    logic [11:0] m1 = '0;
    logic [14:0] m2 = '0, m3 = '0;
    logic [2:0]  fcnt = '0;
    logic [11:0] c_inc1 = '0;
    logic [7:0]  c_lvl = '0;
    logic [1:0]  c_mode = '0;
    logic [2:0]  c_en = '0;
    logic [14:0] c_i2 = '0, c_s2 = '0, c_i3 = '0, c_s3 = '0;

    task automatic check(input logic [7:0] ph, input logic [7:0] lvl,
                         input logic [7:0] eph, input logic [7:0] elvl, input string tag);
        total++;
        if (ph !== eph || lvl !== elvl) begin
            bad++;
            $display("FAIL %s: phase=%h burst=%h expected phase=%h burst=%h",
                     tag, ph, lvl, eph, elvl);
        end
    endtask

    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            item_t it;
            it = exp_q.pop_front();
            check(phase_o, burst_lvl_o, it.ph, it.lvl, it.tag);
        end
    end

    task automatic model_step();
        logic [15:0] s;
        logic c3, c2;
        c3 = 1'b0; c2 = 1'b0;
        if (c_en[2]) begin
            s = {1'b0, m3} + {1'b0, c_i3};
            if (s >= {1'b0, c_s3}) begin s = s - {1'b0, c_s3}; c3 = 1'b1; end
            m3 = s[14:0];
        end
        if (c_en[1]) begin
            s = {1'b0, m2} + {1'b0, c_i2} + {15'd0, c3};
            if (s >= {1'b0, c_s2}) begin s = s - {1'b0, c_s2}; c2 = 1'b1; end
            m2 = s[14:0];
        end
        if (c_en[0]) m1 = m1 + c_inc1 + {11'd0, c2};
    endtask

    task automatic cyc(input bit pix, input bit fs, input string tag);
        bit clr;
        item_t it;
        @(negedge clk);
        pix_en_i = pix;
        field_start_i = fs;
        @(posedge clk);
        #1;
        pix_en_i = 1'b0;
        field_start_i = 1'b0;
        clr = 1'b0;
        if (fs) begin
            fcnt = fcnt + 1'b1;
            case (c_mode)
                2'd0: clr = (fcnt[0] == 1'b0);
                2'd1: clr = (fcnt[1:0] == 2'b00);
                2'd2: clr = (fcnt == 3'b000);
                default: clr = 1'b0;
            endcase
        end
        if (clr) begin m1 = '0; m2 = '0; m3 = '0; end
        else if (pix) model_step();
        it.ph = m1[11:4];
        it.lvl = c_lvl;
        it.tag = tag;
        exp_q.push_back(it);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we_i = 1'b1;
        cfg_addr_i = a;
        cfg_wdata_i = d;
        @(posedge clk);
        #1;
        cfg_we_i = 1'b0;
        case (a)
            2'd0: begin
                c_inc1 = d[11:0]; c_lvl = d[19:12];
                c_mode = d[21:20]; c_en = d[24:22];
            end
            2'd1: begin c_i2 = d[14:0]; c_s2 = d[30:16]; end
            2'd2: begin c_i3 = d[14:0]; c_s3 = d[30:16]; end
            default: ;
        endcase
    endtask

    function automatic logic [31:0] ctrl(input logic [11:0] inc, input logic [7:0] lvl,
                                         input logic [1:0] mode, input logic [2:0] en);
        return {7'd0, en, mode, lvl, inc};
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check(phase_o, burst_lvl_o, 8'h00, 8'h00, "R1 reset");

        wr(2'd1, {1'b0, 15'd7, 1'b0, 15'd3});
        wr(2'd2, {1'b0, 15'd9, 1'b0, 15'd5});
        wr(2'd0, ctrl(12'h123, 8'h5A, 2'd3, 3'b001));
        cyc(1'b0, 1'b0, "R9 burst after write");
        for (int i = 0; i < 20; i++) cyc(1'b1, 1'b0, "R2 coarse stepping");
        for (int i = 0; i < 4; i++)  cyc(1'b0, 1'b0, "R3 idle hold");
        wr(2'd0, ctrl(12'h0F7, 8'hC3, 2'd3, 3'b011));
        for (int i = 0; i < 20; i++) cyc(1'b1, 1'b0, "R4 middle carry");
        wr(2'd0, ctrl(12'h0F7, 8'hC3, 2'd3, 3'b111));
        for (int i = 0; i < 30; i++) cyc(1'b1, 1'b0, "R5 fine carry");
        wr(2'd0, ctrl(12'h0F7, 8'hC3, 2'd3, 3'b101));
        for (int i = 0; i < 12; i++) cyc(1'b1, 1'b0, "R6 middle off");
        wr(2'd0, ctrl(12'h0F7, 8'hC3, 2'd3, 3'b110));
        for (int i = 0; i < 6; i++)  cyc(1'b1, 1'b0, "R6 coarse off");
        // R8 never clears
        wr(2'd0, ctrl(12'h2B1, 8'h11, 2'd3, 3'b111));
        for (int f = 0; f < 9; f++) begin
            cyc(1'b1, 1'b0, "R8 step");
            cyc(1'b0, 1'b1, "R8 field no clear");
        end
        // R7 modes 0, 1, 2
        for (int md = 0; md < 3; md++) begin
            wr(2'd0, ctrl(12'h2B1, 8'h22, md[1:0], 3'b111));
            for (int f = 0; f < 9; f++) begin
                cyc(1'b1, 1'b0, "R7 step");
                cyc(1'b1, 1'b0, "R7 step");
                cyc(1'b0, 1'b1, "R7 field clear period");
            end
        end
        // R10 clear vs pixel in same cycle
        wr(2'd0, ctrl(12'h2B1, 8'h33, 2'd0, 3'b111));
        for (int f = 0; f < 6; f++) begin
            cyc(1'b1, 1'b0, "R10 step");
            cyc(1'b1, 1'b1, "R10 field with pixel");
        end
        // R11 address 3 write changes nothing
        wr(2'd3, 32'hFFFF_FFFF);
        for (int i = 0; i < 8; i++) cyc(1'b1, 1'b0, "R11 addr3 ignored");
        // R11 address 0/1 layout with new values
        wr(2'd1, {1'b0, 15'd1000, 1'b0, 15'd777});
        wr(2'd2, {1'b0, 15'd31, 1'b0, 15'd30});
        wr(2'd0, ctrl(12'hFFF, 8'hE7, 2'd1, 3'b111));
        for (int i = 0; i < 25; i++) cyc(1'b1, 1'b0, "R11 field layout");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            total++; bad++;
            $display("FAIL R2: queue left=%0d expected=0", exp_q.size());
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule